// File: doc/BRIEF.md
# Unaligned Partial-Word Load/Store Merger

This block performs the left and right halves of an unaligned 32-bit register access against a byte-addressed memory, one byte per memory handshake. A load walks a run of consecutive memory bytes and drops each one into a single lane of the register value supplied with the command. The other lanes keep the value they had. The merged word is returned sign-extended on a wider result bus. A store walks the same kind of run and sends one register byte to each address.

The low two address bits give the length of the run. A left access starts at the given address, steps upward and fills lanes from the most significant lane down. A right access starts at the given address, steps downward and fills lanes from the least significant lane up. A pair of left and right accesses to the two ends of an unaligned word therefore covers all four bytes. The block takes one command at a time and issues byte requests until the run is complete. It then raises a one-cycle done strobe with the result.

Top module: `unaligned_pw_merge`

## Requirements
- R1: A left load (cmdOp = 0) reads address A, then A+1, A+2 and so on, and puts the byte of step k into register bits [31-8k : 24-8k].
- R2: A right load (cmdOp = 1) reads address A, then A-1, A-2 and so on, and puts the byte of step k into register bits [8k+7 : 8k].
- R3: A load changes only the lanes it reads into; every other lane of resData[31:0] equals the same lane of cmdReg.
- R4: For a load, resData[63:32] equals 32 copies of bit 31 of the merged word.
- R5: A left store (cmdOp = 2, memWe = 1) writes cmdReg bits [31-8k : 24-8k] to address A+k on step k.
- R6: A right store (cmdOp = 3, memWe = 1) writes cmdReg bits [8k+7 : 8k] to address A-k on step k.
- R7: With offset = cmdAddr[1:0], a left access performs 4 - offset byte handshakes and a right access performs offset + 1, and memory outside that run is left unchanged.
- R8: While memReq is high and memReady is low, memAddr, memWdata and memWe hold their values, and the engine does not advance.
- R9: resDone is high for exactly one cycle, the cycle right after the last byte handshake (memReq and memReady both high).
- R10: A command presented while busy is high is ignored and has no effect on the running operation.
- R11: During and after reset, busy, memReq and resDone are low until a command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Command present; taken when busy is low |
| cmdOp | input | 2 | 0 left load, 1 right load, 2 left store, 3 right store |
| cmdAddr | input | 32 | Byte address of the first access |
| cmdReg | input | 32 | Register value to merge into or to store from |
| busy | output | 1 | An operation is in progress |
| memReq | output | 1 | Byte request valid |
| memAddr | output | 32 | Byte address of the current request |
| memWdata | output | 8 | Byte written on a store |
| memWe | output | 1 | High for store requests |
| memRdata | input | 8 | Byte returned for memAddr, valid with memReady |
| memReady | input | 1 | Memory completes the current byte request |
| resDone | output | 1 | One-cycle completion strobe |
| resData | output | 64 | Merged load word sign-extended from bit 31 |

## Verification
Each of the four operations is run at all four address offsets. This separates runs of one to four bytes and shows that lane steering and address direction depend on both operation and offset. Register values with bit 31 set and clear, together with memory bytes above and below 0x80, separate the sign-extension source: a byte just loaded or a lane kept from the register. Runs with a memory that always answers at once are compared with runs that stall two cycles in three, so that a design advancing without memReady, or reporting done at the wrong time, gives a different result. A command presented during a stalled operation shows whether the busy engine really ignores new commands.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  typedef enum logic [1:0] {
    OP_LOAD_LEFT   = 2'd0,
    OP_LOAD_RIGHT  = 2'd1,
    OP_STORE_LEFT  = 2'd2,
    OP_STORE_RIGHT = 2'd3
  } opKind_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic start;  // capture a new command
    logic step;   // current byte handshake completes
  } dpStrobe_t;

endpackage

// File: rtl/merge_lane.sv
// Selects one byte lane of a word: reads it out and replaces it with a new byte.
module merge_lane #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic [IDX_W-1:0]  laneIdx,
  input  logic [DATA_W-1:0] word,
  input  logic [7:0]        inByte,
  output logic [7:0]        outByte,
  output logic [DATA_W-1:0] merged
);

  logic [LANES-1:0] laneHit;
  logic [7:0]       pick [LANES];

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign laneHit[g]          = (laneIdx == IDX_W'(g));
    assign merged[g*8 +: 8]    = laneHit[g] ? inByte : word[g*8 +: 8];
    assign pick[g]             = laneHit[g] ? word[g*8 +: 8] : 8'h00;
  end

  always_comb begin
    outByte = 8'h00;
    for (int i = 0; i < LANES; i++) begin
      outByte = outByte | pick[i];
    end
  end

endmodule

// File: rtl/merge_ctrl.sv
// Sequencer: idle / transfer, and the registered completion strobe.
module merge_ctrl
  import pwm_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdValid,
  input  logic      memReady,
  input  logic      lastStep,
  output dpStrobe_t strb,
  output logic      busy,
  output logic      resDone
);

  typedef enum logic {ST_IDLE, ST_XFER} state_t;

  state_t stateQ;
  logic   finish;

  always_comb begin
    strb.start = (stateQ == ST_IDLE) && cmdValid;
    strb.step  = (stateQ == ST_XFER) && memReady;
    finish     = strb.step && lastStep;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      resDone <= 1'b0;
    end else begin
      resDone <= finish;
      case (stateQ)
        ST_IDLE: if (strb.start) stateQ <= ST_XFER;
        ST_XFER: if (finish)     stateQ <= ST_IDLE;
        default:                 stateQ <= ST_IDLE;
      endcase
    end
  end

  assign busy = (stateQ == ST_XFER);

endmodule

// File: rtl/merge_dpath.sv
// Datapath: address walk, step counter, working register and lane steering.
module merge_dpath
  import pwm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int RES_W  = 64,
  localparam int LANES = DATA_W / 8,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [1:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdReg,
  input  logic [7:0]        memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  output logic              memWe,
  output logic              lastStep,
  output logic [RES_W-1:0]  resData
);

  opKind_t           opQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [IDX_W-1:0]  stepQ;
  logic [IDX_W-1:0]  lastIdxQ;

  opKind_t           cmdKind;
  logic              cmdLeft;
  logic [IDX_W-1:0]  cmdOffset;
  logic [IDX_W-1:0]  cmdLastIdx;

  logic              isLeft;
  logic              isLoad;
  logic [IDX_W-1:0]  laneIdx;
  logic [DATA_W-1:0] mergedWord;
  logic [7:0]        laneByte;

  // Run length comes from the low address bits: left runs end at the top of
  // the aligned word, right runs end at its bottom.
  always_comb begin
    cmdKind    = opKind_t'(cmdOp);
    cmdLeft    = (cmdKind == OP_LOAD_LEFT) || (cmdKind == OP_STORE_LEFT);
    cmdOffset  = cmdAddr[IDX_W-1:0];
    cmdLastIdx = cmdLeft ? (IDX_W'(LANES - 1) - cmdOffset) : cmdOffset;
  end

  always_comb begin
    isLeft  = (opQ == OP_LOAD_LEFT) || (opQ == OP_STORE_LEFT);
    isLoad  = (opQ == OP_LOAD_LEFT) || (opQ == OP_LOAD_RIGHT);
    laneIdx = isLeft ? (IDX_W'(LANES - 1) - stepQ) : stepQ;
  end

  merge_lane #(.DATA_W(DATA_W)) uLane (
    .laneIdx (laneIdx),
    .word    (dataQ),
    .inByte  (memRdata),
    .outByte (laneByte),
    .merged  (mergedWord)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opQ      <= OP_LOAD_LEFT;
      addrQ    <= '0;
      dataQ    <= '0;
      stepQ    <= '0;
      lastIdxQ <= '0;
    end else if (strb.start) begin
      opQ      <= cmdKind;
      addrQ    <= cmdAddr;
      dataQ    <= cmdReg;
      stepQ    <= '0;
      lastIdxQ <= cmdLastIdx;
    end else if (strb.step) begin
      if (isLoad) dataQ <= mergedWord;
      addrQ <= isLeft ? (addrQ + ADDR_W'(1)) : (addrQ - ADDR_W'(1));
      stepQ <= stepQ + IDX_W'(1);
    end
  end

  assign memAddr  = addrQ;
  assign memWdata = laneByte;
  assign memWe    = !isLoad;
  assign lastStep = (stepQ == lastIdxQ);
  assign resData  = {{(RES_W - DATA_W){dataQ[DATA_W-1]}}, dataQ};

endmodule

// File: rtl/unaligned_pw_merge.sv
module unaligned_pw_merge
  import pwm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int RES_W  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdReg,
  output logic              busy,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  output logic              memWe,
  input  logic [7:0]        memRdata,
  input  logic              memReady,
  output logic              resDone,
  output logic [RES_W-1:0]  resData
);

  dpStrobe_t strb;
  logic      lastStep;

  merge_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .memReady (memReady),
    .lastStep (lastStep),
    .strb     (strb),
    .busy     (busy),
    .resDone  (resDone)
  );

  merge_dpath #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .RES_W  (RES_W)
  ) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cmdOp    (cmdOp),
    .cmdAddr  (cmdAddr),
    .cmdReg   (cmdReg),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .memWe    (memWe),
    .lastStep (lastStep),
    .resData  (resData)
  );

  assign memReq = busy;

endmodule

// File: rtl/merge_chk.sv
module merge_chk #(
  parameter int ADDR_W = 32,
  parameter int LANES  = 4,
  localparam int CNT_W = $clog2(LANES + 1) + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic [7:0]        memWdata,
  input logic              memWe,
  input logic              memReady,
  input logic              resDone
);

  logic [CNT_W-1:0] hsCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    hsCnt <= '0;
    else if (resDone)             hsCnt <= '0;
    else if (memReq && memReady)  hsCnt <= hsCnt + CNT_W'(1);
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && $stable(memAddr) && $stable(memWdata) && $stable(memWe)));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    resDone |=> !resDone);

  // R9
  done_after_hs_chk: assert property (@(posedge clk) disable iff (!rstN)
    resDone |-> $past(memReq && memReady));

  // R9
  req_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memReq) |-> resDone);

  // R1 R2 address steps by one per byte within a run
  addr_walk_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((memReq && memReady) ##1 memReq) |->
      ((memAddr == $past(memAddr) + ADDR_W'(1)) || (memAddr == $past(memAddr) - ADDR_W'(1))));

  // R7
  run_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    resDone |-> ((hsCnt >= CNT_W'(1)) && (hsCnt <= CNT_W'(LANES))));

  // R7
  run_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (hsCnt < CNT_W'(LANES)));

  // R11
  reset_idle_chk: assert property (@(posedge clk)
    !rstN |=> (!memReq && !resDone));

endmodule

bind unaligned_pw_merge merge_chk #(
  .ADDR_W (ADDR_W),
  .LANES  (DATA_W / 8)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .memReq   (memReq),
  .memAddr  (memAddr),
  .memWdata (memWdata),
  .memWe    (memWe),
  .memReady (memReady),
  .resDone  (resDone)
);

// File: tb/sim_unaligned_pw_merge.sv
module sim_unaligned_pw_merge;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdOp = 2'd0;
  logic [31:0] cmdAddr = '0;
  logic [31:0] cmdReg = '0;
  logic        busy;
  logic        memReq;
  logic [31:0] memAddr;
  logic [7:0]  memWdata;
  logic        memWe;
  logic [7:0]  memRdata;
  logic        memReady = 1'b0;
  logic        resDone;
  logic [63:0] resData;

  logic [7:0]  mem [256];
  int          nChecks = 0;
  int          nFail = 0;

  always #5 clk = ~clk;

  assign memRdata = mem[memAddr[7:0]];

  unaligned_pw_merge u0 (
    .clk, .rstN, .cmdValid, .cmdOp, .cmdAddr, .cmdReg, .busy, .memReq,
    .memAddr, .memWdata, .memWe, .memRdata, .memReady, .resDone, .resData
  );

  // op[66:65] addr[64:33] reg[32:1] stall[0]
  localparam int NVEC = 16;
  localparam logic [66:0] VEC [NVEC] = '{
    {2'd0, 32'h0000_0040, 32'hDEAD_BEEF, 1'b0},
    {2'd0, 32'h0000_0041, 32'h1234_5678, 1'b1},
    {2'd0, 32'h0000_0042, 32'hCAFE_F00D, 1'b0},
    {2'd0, 32'h0000_0043, 32'h00AB_CDEF, 1'b1},
    {2'd1, 32'h0000_0050, 32'h8000_1234, 1'b0},
    {2'd1, 32'h0000_0051, 32'h0BAD_C0DE, 1'b1},
    {2'd1, 32'h0000_0052, 32'h55AA_33CC, 1'b0},
    {2'd1, 32'h0000_0053, 32'h1357_2468, 1'b1},
    {2'd2, 32'h0000_0060, 32'h0102_0304, 1'b0},
    {2'd2, 32'h0000_0061, 32'hA1B2_C3D4, 1'b1},
    {2'd2, 32'h0000_0062, 32'h5566_7788, 1'b0},
    {2'd2, 32'h0000_0063, 32'hE0F1_0213, 1'b1},
    {2'd3, 32'h0000_0070, 32'h2468_ACE0, 1'b1},
    {2'd3, 32'h0000_0071, 32'h1122_3344, 1'b0},
    {2'd3, 32'h0000_0072, 32'h9988_7766, 1'b0},
    {2'd3, 32'h0000_0073, 32'hF0E1_D2C3, 1'b1}
  };

  function automatic logic [7:0] memPat(int i);
    return 8'(((i & 255) * 37 + 11) & 255);
  endfunction

  function automatic int runLen(logic [1:0] op, logic [31:0] a);
    return (op == 2'd0 || op == 2'd2) ? 4 - int'(a[1:0]) : int'(a[1:0]) + 1;
  endfunction

  function automatic int stepAddr(logic [1:0] op, logic [31:0] a, int k);
    return (op == 2'd0 || op == 2'd2) ? int'(a[7:0]) + k : int'(a[7:0]) - k;
  endfunction

  function automatic logic [31:0] mdlLoad(logic [1:0] op, logic [31:0] a, logic [31:0] r);
    logic [31:0] v = r;
    for (int k = 0; k < runLen(op, a); k++) begin
      if (op == 2'd0) v[31-8*k -: 8] = memPat(stepAddr(op, a, k));
      else            v[8*k +: 8]    = memPat(stepAddr(op, a, k));
    end
    return v;
  endfunction

  function automatic logic [31:0] touchMask(logic [1:0] op, logic [31:0] a);
    logic [31:0] m = '0;
    for (int k = 0; k < runLen(op, a); k++) begin
      if (op == 2'd0) m[31-8*k -: 8] = 8'hFF;
      else            m[8*k +: 8]    = 8'hFF;
    end
    return m;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doOp(input logic [1:0] op, input logic [31:0] a, input logic [31:0] rv,
                      input bit stall, input bit poke);
    int          cnt = 0;
    int          lastHs = -1;
    int          doneCyc = -1;
    logic [31:0] seen [4];
    logic [63:0] res = '0;
    bit          prevStall = 1'b0;
    logic [31:0] stAddr = '0;
    logic [7:0]  stWd = '0;
    logic [31:0] expW;
    bit          left = (op == 2'd0 || op == 2'd2);
    for (int i = 0; i < 256; i++) mem[i] = memPat(i);
    for (int i = 0; i < 4; i++) seen[i] = '0;
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdAddr = a; cmdReg = rv; memReady = 1'b0;
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 2'd0; cmdAddr = '0; cmdReg = '0;
    for (int c = 0; c < 60; c++) begin
      if (poke && c == 1) begin
        cmdValid = 1'b1; cmdOp = 2'd3; cmdAddr = 32'h0000_0090; cmdReg = 32'hFFFF_FFFF;
      end else begin
        cmdValid = 1'b0;
      end
      memReady = stall ? (c % 3 == 2) : 1'b1;
      #1;
      if (prevStall)
        check(memAddr == stAddr && memWdata == stWd && memReq, "R8 stalled request held",
              {memAddr, 24'h0, memWdata}, {stAddr, 24'h0, stWd});
      prevStall = memReq && !memReady;
      stAddr = memAddr; stWd = memWdata;
      if (resDone) begin
        doneCyc = c; res = resData;
        break;
      end
      if (memReq && memReady) begin
        if (cnt < 4) seen[cnt] = memAddr;
        cnt++;
        lastHs = c;
        if (memWe) mem[memAddr[7:0]] = memWdata;
      end
      @(negedge clk);
    end
    cmdValid = 1'b0;
    memReady = 1'b0;
    @(negedge clk);
    #1;
    check(!resDone, "R9 done lasts one cycle", 64'(resDone), 64'd0);
    check(doneCyc >= 0 && doneCyc == lastHs + 1, "R9 done follows last handshake",
          64'(doneCyc), 64'(lastHs + 1));
    check(cnt == runLen(op, a), "R7 byte count", 64'(cnt), 64'(runLen(op, a)));
    for (int k = 0; k < runLen(op, a) && k < 4; k++)
      check(seen[k][7:0] == 8'(stepAddr(op, a, k)), left ? "R1 R5 address order" : "R2 R6 address order",
            64'(seen[k]), 64'(stepAddr(op, a, k) & 255));
    if (op[1] == 1'b0) begin
      expW = mdlLoad(op, a, rv);
      check(res[31:0] == expW, left ? "R1 left load word" : "R2 right load word", res, 64'(expW));
      check((res[31:0] & ~touchMask(op, a)) == (rv & ~touchMask(op, a)), "R3 kept lanes",
            64'(res[31:0] & ~touchMask(op, a)), 64'(rv & ~touchMask(op, a)));
      check(res[63:32] == {32{expW[31]}}, "R4 sign extension", 64'(res[63:32]), 64'({32{expW[31]}}));
    end else begin
      for (int k = 0; k < runLen(op, a); k++) begin
        logic [7:0] eb = left ? rv[31-8*k -: 8] : rv[8*k +: 8];
        check(mem[stepAddr(op, a, k) & 255] == eb, left ? "R5 left store byte" : "R6 right store byte",
              64'(mem[stepAddr(op, a, k) & 255]), 64'(eb));
      end
      check(mem[stepAddr(op, a, runLen(op, a)) & 255] == memPat(stepAddr(op, a, runLen(op, a))),
            "R7 byte past run untouched", 64'(mem[stepAddr(op, a, runLen(op, a)) & 255]),
            64'(memPat(stepAddr(op, a, runLen(op, a)))));
    end
    check(mem[8'h90] == memPat(8'h90), "R10 ignored command wrote nothing", 64'(mem[8'h90]), 64'(memPat(8'h90)));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL R9 watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 256; i++) mem[i] = memPat(i);
    repeat (3) @(negedge clk);
    #1;
    // R11 reset state
    check(!busy && !memReq && !resDone, "R11 reset idle", {61'd0, busy, memReq, resDone}, 64'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    check(!busy && !memReq && !resDone, "R11 idle after reset", {61'd0, busy, memReq, resDone}, 64'd0);

    for (int v = 0; v < NVEC; v++)
      doOp(VEC[v][66:65], VEC[v][64:33], VEC[v][32:1], VEC[v][0], 1'b0);

    // R10 command during busy is ignored: run must match an undisturbed one
    doOp(2'd0, 32'h0000_0041, 32'h8765_4321, 1'b1, 1'b1);
    doOp(2'd3, 32'h0000_00A2, 32'h7F00_FF01, 1'b1, 1'b1);

    // R4 single-byte left load with a negative memory byte, back to back
    doOp(2'd0, 32'h0000_0043, 32'h7FFF_FFFF, 1'b0, 1'b0);
    // R3 right load offset 0 keeps three register lanes, sign from register
    doOp(2'd1, 32'h0000_0084, 32'hFEDC_BA98, 1'b0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule